// File: doc/BRIEF.md
# Telephony Signalling Tone Generator

This block produces signed digital sine samples for the call-setup tones a modem places on a telephone line. It has two numerically controlled oscillators. Each is a 32-bit phase accumulator followed by a quarter-wave sine lookup. Together they give the sixteen dual-tone dial digits, two answer-tone variants, a guard tone and a fax calling tone. The calling tone is keyed on and off in hardware. The increment constant for every frequency is computed at elaboration from the sample-rate parameter.

A controller pulses `start` with a tone code and a digit code, then supplies one `sampleEn` pulse per output sample. The generator keeps producing samples until `stop` is pulsed. Level control, pulse dialing and conversion to analog are left to the surrounding logic.

Top module: `tone_gen`

## Requirements
- R1: After reset, `busy` is 0 and `sample` is 0.
- R2: A `start` pulse latches `toneSel` and `digit`, sets `busy`, clears `sample` to 0 and zeroes both phases, all on the same clock edge. A `stop` pulse clears `busy` and `sample` on the same edge. When both pulses are high together, `stop` wins.
- R3: Each oscillator advances its phase by round(f·2^32 / SAMPLE_HZ) only on a `sampleEn` edge while busy. Sample number k after `start` (k from 0) equals the sine of phase k·increment. On any other edge `sample` holds its value.
- R4: With `toneSel` = 0, the digit code selects a frequency pair as follows.
  - Codes 1, 2, 3 use 697 Hz with 1209, 1336 and 1477 Hz respectively.
  - Codes 4, 5, 6 use 770 Hz with the same three high tones.
  - Codes 7, 8, 9 use 852 Hz with the same three high tones.
  - Code 10 (star) uses 941/1209 Hz, code 0 uses 941/1336 Hz and code 11 (hash) uses 941/1477 Hz.
  - Codes 12 to 15 (A to D) use 697, 770, 852 and 941 Hz respectively, each with 1633 Hz.
- R5: In dual-tone mode each oscillator's sine is halved with an arithmetic shift before the two are summed, so the sum peaks near half scale on each tone and cannot overflow.
- R6: `toneSel` = 1 gives a single 2100 Hz answer tone. `toneSel` = 2 gives a single 2225 Hz answer tone. Both are at full scale.
- R7: `toneSel` = 3 gives a single full-scale 1800 Hz guard tone.
- R8: `toneSel` = 4 gives a 1100 Hz calling tone. The tone sounds for SAMPLE_HZ/2 samples and is silent (exactly 0) for 3·SAMPLE_HZ samples, and the pattern repeats until stopped. Each burst restarts at zero phase.
- R9: `toneSel` codes 5 to 7 set `busy` but give an output of exactly 0.
- R10: While not busy, `sample` is 0 whatever `sampleEn` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | One pulse per output sample |
| toneSel | input | 3 | Tone code, latched by `start` |
| digit | input | 4 | Dial digit code, latched by `start` |
| start | input | 1 | Begin a tone with the given codes |
| stop | input | 1 | End the tone and silence the output |
| sample | output | SAMPLE_W | Signed sine sample |
| busy | output | 1 | A tone is active |

## Verification
Every result is registered. The effect of a `start` or `stop` is seen one clock edge after the pulse. A sample requested by `sampleEn` appears on that same edge, and the k-th enable after `start` carries phase k·increment.

The bench drives inputs just after a falling edge and reads outputs at the next falling edge. Each read therefore sees exactly one rising edge. The bench counts the enables it has issued and derives from that count the phase, and the cadence position, of every expected sample. Edges with the enable low are checked for an unchanged sample.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam int PHASE_W = 32;

  localparam logic [2:0] SEL_DIGIT    = 3'd0;
  localparam logic [2:0] SEL_ANS_ITU  = 3'd1;
  localparam logic [2:0] SEL_ANS_BELL = 3'd2;
  localparam logic [2:0] SEL_GUARD    = 3'd3;
  localparam logic [2:0] SEL_CALL     = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPhase;
    logic advance;
    logic mute;
    logic dual;
  } dpCtrl_t;

  function automatic logic [PHASE_W-1:0] phaseStep(int unsigned hz, int unsigned fs);
    longint unsigned num;
    num = (longint'(hz) << PHASE_W) + longint'(fs / 2);
    return PHASE_W'(num / longint'(fs));
  endfunction

  function automatic int unsigned lowGroupHz(int r);
    case (r)
      0: return 697;
      1: return 770;
      2: return 852;
      default: return 941;
    endcase
  endfunction

  function automatic int unsigned highGroupHz(int c);
    case (c)
      0: return 1209;
      1: return 1336;
      2: return 1477;
      default: return 1633;
    endcase
  endfunction

  // rational sine approximation at the centre of quarter-table slot idx
  function automatic int quarterSine(int idx, int n, int amp);
    longint a, h, num, den;
    a   = 2 * longint'(idx) + 1;
    h   = 4 * longint'(n);
    num = 16 * a * (h - a);
    den = 5 * h * h - 4 * a * (h - a);
    return int'((num * longint'(amp) + den / 2) / den);
  endfunction

endpackage

// File: rtl/tone_ctrl.sv
module tone_ctrl
  import tone_pkg::*;
#(
  parameter int unsigned SAMPLE_HZ = 8000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleEn,
  input  logic [2:0]         toneSel,
  input  logic [3:0]         digit,
  input  logic               start,
  input  logic               stop,
  output logic               busy,
  output dpCtrl_t            ctl,
  output logic [PHASE_W-1:0] incA,
  output logic [PHASE_W-1:0] incB
);

  localparam int unsigned ON_LEN    = SAMPLE_HZ / 2;
  localparam int unsigned OFF_LEN   = 3 * SAMPLE_HZ;
  localparam int unsigned CYCLE_LEN = ON_LEN + OFF_LEN;
  localparam int          CNT_W     = $clog2(CYCLE_LEN);

  localparam logic [PHASE_W-1:0] INC_ITU   = phaseStep(2100, SAMPLE_HZ);
  localparam logic [PHASE_W-1:0] INC_BELL  = phaseStep(2225, SAMPLE_HZ);
  localparam logic [PHASE_W-1:0] INC_GUARD = phaseStep(1800, SAMPLE_HZ);
  localparam logic [PHASE_W-1:0] INC_CALL  = phaseStep(1100, SAMPLE_HZ);

  logic [2:0]         modeQ;
  logic [3:0]         digQ;
  logic [CNT_W-1:0]   cadCnt;
  logic [PHASE_W-1:0] lowInc  [4];
  logic [PHASE_W-1:0] highInc [4];
  logic [1:0]         rowSel, colSel;
  logic               callOff;

  for (genvar g = 0; g < 4; g++) begin : g_group
    assign lowInc[g]  = phaseStep(lowGroupHz(g), SAMPLE_HZ);
    assign highInc[g] = phaseStep(highGroupHz(g), SAMPLE_HZ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      modeQ  <= SEL_DIGIT;
      digQ   <= '0;
      cadCnt <= '0;
    end else if (stop) begin
      busy   <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      modeQ  <= toneSel;
      digQ   <= digit;
      cadCnt <= '0;
    end else if (busy && sampleEn && modeQ == SEL_CALL) begin
      cadCnt <= (cadCnt == CNT_W'(CYCLE_LEN - 1)) ? '0 : cadCnt + 1'b1;
    end
  end

  always_comb begin
    case (digQ)
      4'd1, 4'd2, 4'd3, 4'd12: rowSel = 2'd0;
      4'd4, 4'd5, 4'd6, 4'd13: rowSel = 2'd1;
      4'd7, 4'd8, 4'd9, 4'd14: rowSel = 2'd2;
      default:                 rowSel = 2'd3;
    endcase
    case (digQ)
      4'd1, 4'd4, 4'd7, 4'd10: colSel = 2'd0;
      4'd2, 4'd5, 4'd8, 4'd0:  colSel = 2'd1;
      4'd3, 4'd6, 4'd9, 4'd11: colSel = 2'd2;
      default:                 colSel = 2'd3;
    endcase
  end

  always_comb begin
    callOff      = (modeQ == SEL_CALL) && (cadCnt >= CNT_W'(ON_LEN));
    ctl.clrPhase = start | stop;
    ctl.advance  = busy & sampleEn & ~start & ~stop;
    ctl.mute     = callOff | (modeQ > SEL_CALL);
    ctl.dual     = (modeQ == SEL_DIGIT);
    incB         = highInc[colSel];
    case (modeQ)
      SEL_DIGIT:    incA = lowInc[rowSel];
      SEL_ANS_ITU:  incA = INC_ITU;
      SEL_ANS_BELL: incA = INC_BELL;
      SEL_GUARD:    incA = INC_GUARD;
      SEL_CALL:     incA = INC_CALL;
      default:      incA = '0;
    endcase
  end

endmodule

// File: rtl/tone_sine.sv
module tone_sine #(
  parameter int SAMPLE_W = 16,
  parameter int TBL_BITS = 6
) (
  input  logic [TBL_BITS+1:0]        phTop,
  output logic signed [SAMPLE_W-1:0] value
);
  import tone_pkg::*;

  localparam int N     = 1 << TBL_BITS;
  localparam int MAG_W = SAMPLE_W - 1;
  localparam int AMP   = (1 << MAG_W) - 1;

  logic [MAG_W-1:0]    qTab [N];
  logic [1:0]          quad;
  logic [TBL_BITS-1:0] idx, slot;
  logic [MAG_W-1:0]    mag;

  for (genvar g = 0; g < N; g++) begin : g_tab
    assign qTab[g] = MAG_W'(quarterSine(g, N, AMP));
  end

  always_comb begin
    quad  = phTop[TBL_BITS+1:TBL_BITS];
    idx   = phTop[TBL_BITS-1:0];
    slot  = quad[0] ? ~idx : idx;
    mag   = qTab[slot];
    value = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

endmodule

// File: rtl/tone_dp.sv
module tone_dp
  import tone_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int TBL_BITS = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrl_t                    ctl,
  input  logic [PHASE_W-1:0]         incA,
  input  logic [PHASE_W-1:0]         incB,
  output logic signed [SAMPLE_W-1:0] sample
);

  logic [PHASE_W-1:0]         inc   [2];
  logic [PHASE_W-1:0]         phase [2];
  logic signed [SAMPLE_W-1:0] sine  [2];
  logic signed [SAMPLE_W-1:0] mix;

  assign inc[0] = incA;
  assign inc[1] = incB;

  for (genvar o = 0; o < 2; o++) begin : g_osc
    always_ff @(posedge clk) begin
      if (!rstN || ctl.clrPhase || (ctl.advance && ctl.mute))
        phase[o] <= '0;
      else if (ctl.advance)
        phase[o] <= phase[o] + inc[o];
    end

    tone_sine #(.SAMPLE_W(SAMPLE_W), .TBL_BITS(TBL_BITS)) u_sine (
      .phTop (phase[o][PHASE_W-1 -: TBL_BITS+2]),
      .value (sine[o])
    );
  end

  always_comb begin
    if (ctl.mute)      mix = '0;
    else if (ctl.dual) mix = (sine[0] >>> 1) + (sine[1] >>> 1);
    else               mix = sine[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrPhase) sample <= '0;
    else if (ctl.advance)      sample <= mix;
  end

endmodule

// File: rtl/tone_gen.sv
module tone_gen
  import tone_pkg::*;
#(
  parameter int unsigned SAMPLE_HZ = 8000,
  parameter int          SAMPLE_W  = 16,
  parameter int          TBL_BITS  = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleEn,
  input  logic [2:0]                 toneSel,
  input  logic [3:0]                 digit,
  input  logic                       start,
  input  logic                       stop,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       busy
);

  dpCtrl_t            strobes;
  logic [PHASE_W-1:0] incA, incB;

  tone_ctrl #(.SAMPLE_HZ(SAMPLE_HZ)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .toneSel  (toneSel),
    .digit    (digit),
    .start    (start),
    .stop     (stop),
    .busy     (busy),
    .ctl      (strobes),
    .incA     (incA),
    .incB     (incB)
  );

  tone_dp #(.SAMPLE_W(SAMPLE_W), .TBL_BITS(TBL_BITS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (strobes),
    .incA   (incA),
    .incB   (incB),
    .sample (sample)
  );

endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleEn,
  input logic                start,
  input logic                stop,
  input logic                busy,
  input logic [SAMPLE_W-1:0] sample,
  input logic                advS,
  input logic                muteS
);

  assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    stop |=> (!busy && sample == '0));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !stop) |=> busy);

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sampleEn && !start && !stop) |=> $stable(sample));

  assert_cadence_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (advS && muteS) |=> sample == '0);

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sample == '0);

endmodule

bind tone_gen tone_gen_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sampleEn (sampleEn),
  .start    (start),
  .stop     (stop),
  .busy     (busy),
  .sample   (sample),
  .advS     (strobes.advance),
  .muteS    (strobes.mute)
);

// File: tb/sim_tone_gen.sv
module sim_tone_gen;

  localparam int FS       = 8000;
  localparam int TOL      = 700;
  localparam int ON_LEN   = FS / 2;
  localparam int CYC_LEN  = ON_LEN + 3 * FS;
  localparam int FULL     = 32767;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               sampleEn = 1'b0;
  logic [2:0]         toneSel = '0;
  logic [3:0]         digit = '0;
  logic               start = 1'b0;
  logic               stop = 1'b0;
  logic signed [15:0] sample;
  logic               busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  longint kCnt = 0;
  int curMode = 0;
  int curDig = 0;

  tone_gen u0 (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .toneSel(toneSel),
    .digit(digit), .start(start), .stop(stop), .sample(sample), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint stepOf(int hz);
    return ((longint'(hz) << 32) + FS / 2) / FS;
  endfunction

  function automatic int lowHz(int d);
    case (d)
      1, 2, 3, 12: return 697;
      4, 5, 6, 13: return 770;
      7, 8, 9, 14: return 852;
      default:     return 941;
    endcase
  endfunction

  function automatic int highHz(int d);
    case (d)
      1, 4, 7, 10: return 1209;
      2, 5, 8, 0:  return 1336;
      3, 6, 9, 11: return 1477;
      default:     return 1633;
    endcase
  endfunction

  function automatic int singleHz(int m);
    case (m)
      1: return 2100;
      2: return 2225;
      3: return 1800;
      default: return 1100;
    endcase
  endfunction

  function automatic real sineAt(int hz, longint k);
    longint ph;
    ph = (k * stepOf(hz)) & 64'hFFFF_FFFF;
    return $sin(2.0 * 3.141592653589793 * real'(ph) / 4294967296.0);
  endfunction

  function automatic bit isQuiet(int m, longint k);
    if (m > 4) return 1'b1;
    if (m == 4) return (k % CYC_LEN) >= ON_LEN;
    return 1'b0;
  endfunction

  function automatic int expected(int m, int d, longint k);
    real v;
    if (isQuiet(m, k)) return 0;
    if (m == 0) v = 0.5 * FULL * (sineAt(lowHz(d), k) + sineAt(highHz(d), k));
    else if (m == 4) v = FULL * sineAt(1100, k % CYC_LEN);
    else v = FULL * sineAt(singleHz(m), k);
    return int'($rtoi(v < 0.0 ? v - 0.5 : v + 0.5));
  endfunction

  function automatic string reqOf(int m);
    case (m)
      0: return "R4/R5";
      1, 2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic startTone(input int m, input int d);
    start = 1'b1; toneSel = 3'(m); digit = 4'(d); sampleEn = 1'b0;
    cyc();
    start = 1'b0;
    curMode = m; curDig = d; kCnt = 0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(sample == 16'sd0, "R2 sample cleared by start", int'(sample), 0);
  endtask

  task automatic runSamples(input int n, input int density);
    int got, exp, prev;
    for (int i = 0; i < n; i++) begin
      bit en;
      en = ($urandom % 100) < density;
      prev = int'(sample);
      sampleEn = en;
      cyc();
      got = int'(sample);
      if (en) begin
        exp = expected(curMode, curDig, kCnt);
        if (isQuiet(curMode, kCnt))
          chk(got == 0, reqOf(curMode), got, 0);
        else
          chk((got - exp) <= TOL && (exp - got) <= TOL, reqOf(curMode), got, exp);
        kCnt++;
      end else begin
        chk(got == prev, "R3 hold without enable", got, prev);
      end
    end
    sampleEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R1: reset state
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(sample == 16'sd0, "R1 sample after reset", int'(sample), 0);

    // R10: idle with enables stays zero
    sampleEn = 1'b1;
    repeat (5) begin
      cyc();
      chk(sample == 16'sd0 && busy == 1'b0, "R10 idle output", int'(sample), 0);
    end
    sampleEn = 1'b0;

    // R4 R5: every digit, enable every cycle
    for (int d = 0; d < 16; d++) begin
      startTone(0, d);
      runSamples(30, 100);
    end

    // R6 R7: single tones
    for (int m = 1; m <= 3; m++) begin
      startTone(m, 0);
      runSamples(60, 100);
    end

    // R3: random tones with gapped enables, restart while busy
    for (int r = 0; r < 20; r++) begin
      startTone(int'($urandom % 4), int'($urandom % 16));
      runSamples(60, 30 + int'($urandom % 71));
    end

    // R9: silent codes
    for (int m = 5; m <= 7; m++) begin
      startTone(m, 3);
      runSamples(20, 100);
    end

    // R2: stop and start together, stop wins
    startTone(1, 0);
    runSamples(10, 100);
    start = 1'b1; stop = 1'b1; toneSel = 3'd2; sampleEn = 1'b1;
    cyc();
    start = 1'b0; stop = 1'b0;
    chk(busy == 1'b0, "R2 stop wins busy", int'(busy), 0);
    chk(sample == 16'sd0, "R2 stop wins sample", int'(sample), 0);
    repeat (4) begin
      cyc();
      chk(sample == 16'sd0, "R10 idle after stop", int'(sample), 0);
    end
    sampleEn = 1'b0;

    // R8: calling tone, a full cadence plus the start of the next burst
    startTone(4, 0);
    runSamples(CYC_LEN + 300, 100);
    stop = 1'b1;
    cyc();
    stop = 1'b0;
    chk(busy == 1'b0 && sample == 16'sd0, "R2 stop ends call tone", int'(sample), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule